// File: doc/BRIEF.md
# Three-Wire Serial Control Register Port

This block receives configuration words over a write-only three-wire serial link made of a data line, a bit clock and a latch strobe. Words are 16 bits long and arrive most significant bit first. On the rising edge of the latch strobe, the two lowest bits of the word choose a destination: the left volume register, the right volume register or the control register. The upper 14 bits are written into that register.

All three serial inputs are oversampled in a system clock domain that runs at least four times faster than the serial bit clock. Each input passes through a two-flop synchroniser followed by an edge detector. The control register is split into decoded configuration outputs: de-emphasis selection, serial data format, mute, soft reset, right-justified word length, and the 4x and 2x interpolation enables. Several of these outputs are ORed with external hardware pins. Because of this, a system that never writes the port can still be configured with the pins alone. Reset restores defaults that give a working setup with no writes: full-scale volume, and every control field at zero.

A write to either volume register also raises a one-cycle pulse toward the downstream volume ramp logic, marking that a new target value is available.

Top module: `ser_ctl_port`

## Requirements
- R1: While rst_n is low, and after it is released with no write, both volume outputs are all ones (14'h3FFF) and every control-derived output is zero when all pins are low.
- R2: Data bits are sampled on rising edges of the serial bit clock, most significant bit first. A latch rising edge with word bits [1:0] = 00 loads word bits [15:2] into the left volume output.
- R3: A latch rising edge with word bits [1:0] = 10 loads word bits [15:2] into the right volume output.
- R4: A latch rising edge with word bits [1:0] = 01 loads the control fields from these word bits: [3:2] de-emphasis (00 off, 01 44.1 kHz, 10 32 kHz, 11 48 kHz), [5:4] serial format, [6] mute, [7] soft reset, [9:8] right-justified word length (00 = 24, 01 = 20, 10 = 16), [10] 4x interpolation, [11] 2x interpolation. Word bits [15:12] are discarded and have no effect on any output.
- R5: A latch rising edge with word bits [1:0] = 11 leaves every register output unchanged and raises no pulse.
- R6: When more than 16 bits are clocked in before the latch, the last 16 bits shifted in are the ones loaded.
- R7: Bit clock edges with no latch edge change no output. A later latch edge on its own loads the bits already shifted in.
- R8: The serial format output is the control field ORed with the two format pins. The mute, 4x and 2x outputs are each their control bit ORed with the matching pin.
- R9: The de-emphasis output is the control field with bit 0 ORed with the de-emphasis pin. With the field at 00 the pin gives 01; with the field at 10 the pin gives 11.
- R10: Each left or right volume write raises the matching new-target output for exactly one system clock cycle. The two pulses are never high together. Control writes and ignored writes raise neither.
- R11: Pulling rst_n low after registers have been written restores the defaults of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_in | input | 1 | Serial bit clock |
| ser_dat_in | input | 1 | Serial data, MSB first |
| ser_lat_in | input | 1 | Latch strobe, rising edge loads the word |
| pin_fmt | input | 2 | Serial format pins, ORed with the control field |
| pin_mute | input | 1 | Mute pin |
| pin_intp4 | input | 1 | 4x interpolation pin |
| pin_intp2 | input | 1 | 2x interpolation pin |
| pin_deemph | input | 1 | 44.1 kHz de-emphasis pin |
| vol_left | output | 14 | Left volume target |
| vol_right | output | 14 | Right volume target |
| vol_left_new | output | 1 | One-cycle pulse on a left volume write |
| vol_right_new | output | 1 | One-cycle pulse on a right volume write |
| deemph_sel | output | 2 | Effective de-emphasis selection |
| fmt_sel | output | 2 | Effective serial data format |
| mute | output | 1 | Effective mute |
| soft_rst | output | 1 | Soft reset control bit |
| rj_wlen | output | 2 | Right-justified word length code |
| intp4_sel | output | 1 | Effective 4x interpolation enable |
| intp2_sel | output | 1 | Effective 2x interpolation enable |

## Verification
The hardest cases to reach from the ports are those where the shift register and the latch fall out of step. One is a word with extra leading bits. The other is a full word clocked in with no latch, followed later by a lone latch pulse. The stimulus task therefore takes an arbitrary bit count and an option to omit the latch, and a separate task drives a latch pulse with no clock activity. Most stimulus comes from a vector table that covers each address, including the ignored one and a control word with its reserved bits set. Directed tests then overlay pin values on control fields that already hold non-zero values, so the OR behaviour is visible.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;

   // control register layout, LSB first: de-emphasis occupies the bottom bits
   typedef struct packed {
      logic       intp2;
      logic       intp4;
      logic [1:0] wlen;
      logic       soft_rst;
      logic       mute;
      logic [1:0] fmt;
      logic [1:0] deemph;
   } ctl_fields_t;

   localparam int CTL_BITS = $bits(ctl_fields_t);

   typedef enum logic [1:0] {
      SEL_VOL_L = 2'b00,
      SEL_CTRL  = 2'b01,
      SEL_VOL_R = 2'b10,
      SEL_NONE  = 2'b11
   } reg_sel_e;

endpackage

// File: rtl/ctlp_sync.sv
module ctlp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q,
   output logic rise
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ctlp_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[LAST-1:0], d_async};
         prev  <= chain[LAST];
      end
   end

   assign q    = chain[LAST];
   assign rise = chain[LAST] & ~prev;

   // R2
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/ctlp_shifter.sv
module ctlp_shifter #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              din,
   output logic [WORD_W-1:0] word
);
   generate
      if (WORD_W < 4) begin : g_bad_width
         $error("ctlp_shifter word too narrow");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word <= '0;
      else if (shift_en) word <= {word[WORD_W-2:0], din};
   end

   // R7
   shift_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word != $past(word)) |-> $past(shift_en));

endmodule

// File: rtl/ctlp_regfile.sv
module ctlp_regfile
   import ctlp_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 2,
   parameter int VOL_W  = WORD_W - ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   output logic [VOL_W-1:0]  vol_l,
   output logic [VOL_W-1:0]  vol_r,
   output ctl_fields_t       ctl,
   output logic              vol_l_new,
   output logic              vol_r_new
);
   localparam int DATA_W = WORD_W - ADDR_W;

   generate
      if (ADDR_W != $bits(reg_sel_e)) begin : g_bad_addr
         $error("ctlp_regfile address width must match the select type");
      end
      if (DATA_W != VOL_W) begin : g_bad_vol
         $error("ctlp_regfile volume width must equal the data field");
      end
      if (CTL_BITS > DATA_W) begin : g_bad_ctl
         $error("ctlp_regfile control fields exceed the data field");
      end
   endgenerate

   logic [ADDR_W-1:0] sel;
   logic [DATA_W-1:0] data;

   assign sel  = word[ADDR_W-1:0];
   assign data = word[WORD_W-1:ADDR_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vol_l     <= '1;
         vol_r     <= '1;
         ctl       <= '0;
         vol_l_new <= 1'b0;
         vol_r_new <= 1'b0;
      end else begin
         vol_l_new <= 1'b0;
         vol_r_new <= 1'b0;
         if (load) begin
            case (sel)
               SEL_VOL_L: begin
                  vol_l     <= data;
                  vol_l_new <= 1'b1;
               end
               SEL_VOL_R: begin
                  vol_r     <= data;
                  vol_r_new <= 1'b1;
               end
               SEL_CTRL:  ctl <= ctl_fields_t'(data[CTL_BITS-1:0]);
               default:   ;
            endcase
         end
      end
   end

   // R10
   left_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vol_l_new |=> !vol_l_new);

   // R10
   right_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vol_r_new |=> !vol_r_new);

   // R10
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(vol_l_new && vol_r_new));

   // R2
   vol_l_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vol_l != $past(vol_l)) |-> vol_l_new);

   // R3
   vol_r_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vol_r != $past(vol_r)) |-> vol_r_new);

   // R5
   ctl_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl != $past(ctl)) |-> $past(load));

endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
   import ctlp_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int VOL_W       = WORD_W - ADDR_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_clk_in,
   input  logic             ser_dat_in,
   input  logic             ser_lat_in,
   input  logic [1:0]       pin_fmt,
   input  logic             pin_mute,
   input  logic             pin_intp4,
   input  logic             pin_intp2,
   input  logic             pin_deemph,
   output logic [VOL_W-1:0] vol_left,
   output logic [VOL_W-1:0] vol_right,
   output logic             vol_left_new,
   output logic             vol_right_new,
   output logic [1:0]       deemph_sel,
   output logic [1:0]       fmt_sel,
   output logic             mute,
   output logic             soft_rst,
   output logic [1:0]       rj_wlen,
   output logic             intp4_sel,
   output logic             intp2_sel
);
   localparam int N_IN   = 3;
   localparam int IX_CLK = 0;
   localparam int IX_DAT = 1;
   localparam int IX_LAT = 2;

   logic [N_IN-1:0]   raw_in;
   logic [N_IN-1:0]   sync_q;
   logic [N_IN-1:0]   sync_rise;
   logic [WORD_W-1:0] shift_word;
   ctl_fields_t       ctl;

   assign raw_in[IX_CLK] = ser_clk_in;
   assign raw_in[IX_DAT] = ser_dat_in;
   assign raw_in[IX_LAT] = ser_lat_in;

   // equal depth on every input keeps data aligned with its clock edge
   generate
      for (genvar g = 0; g < N_IN; g++) begin : g_sync
         ctlp_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (raw_in[g]),
            .q       (sync_q[g]),
            .rise    (sync_rise[g])
         );
      end
   endgenerate

   ctlp_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (sync_rise[IX_CLK]),
      .din      (sync_q[IX_DAT]),
      .word     (shift_word)
   );

   ctlp_regfile #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .VOL_W(VOL_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sync_rise[IX_LAT]),
      .word      (shift_word),
      .vol_l     (vol_left),
      .vol_r     (vol_right),
      .ctl       (ctl),
      .vol_l_new (vol_left_new),
      .vol_r_new (vol_right_new)
   );

   // pin overrides merged after the register
   assign fmt_sel    = ctl.fmt | pin_fmt;
   assign mute       = ctl.mute | pin_mute;
   assign intp4_sel  = ctl.intp4 | pin_intp4;
   assign intp2_sel  = ctl.intp2 | pin_intp2;
   assign deemph_sel = ctl.deemph | {1'b0, pin_deemph};
   assign soft_rst   = ctl.soft_rst;
   assign rj_wlen    = ctl.wlen;

endmodule

// File: tb/tb_ser_ctl_port.sv
module tb_ser_ctl_port;

   localparam int HALF_SCK = 32;
   localparam int N_VEC    = 7;

   // table: word, expected left, right, control fields, pulse increments
   localparam logic [15:0] T_WORD [N_VEC] = '{16'h5554, 16'h2AAA, 16'h0000,
                                              16'h0ADD, 16'hF001, 16'h8006, 16'h048F};
   localparam logic [13:0] T_VL   [N_VEC] = '{14'h1555, 14'h1555, 14'h0000,
                                              14'h0000, 14'h0000, 14'h0000, 14'h0000};
   localparam logic [13:0] T_VR   [N_VEC] = '{14'h3FFF, 14'h0AAA, 14'h0AAA,
                                              14'h0AAA, 14'h0AAA, 14'h2001, 14'h2001};
   localparam logic [9:0]  T_CTL  [N_VEC] = '{10'h000, 10'h000, 10'h000,
                                              10'h2B7, 10'h000, 10'h000, 10'h000};
   localparam int          T_PL   [N_VEC] = '{1, 0, 1, 0, 0, 0, 0};
   localparam int          T_PR   [N_VEC] = '{0, 1, 0, 0, 0, 1, 0};
   // rows: R2 R3 R2 R4 R4(reserved bits) R3 R5(address 11)
   localparam int          T_REQ  [N_VEC] = '{2, 3, 2, 4, 4, 3, 5};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0, sdat = 1'b0, slat = 1'b0;
   logic [1:0]  pin_fmt = 2'b00;
   logic        pin_mute = 1'b0, pin_intp4 = 1'b0, pin_intp2 = 1'b0, pin_deemph = 1'b0;
   logic [13:0] vol_left, vol_right;
   logic        vol_left_new, vol_right_new;
   logic [1:0]  deemph_sel, fmt_sel, rj_wlen;
   logic        mute, soft_rst, intp4_sel, intp2_sel;
   logic [9:0]  obs_ctl;

   int n_checks = 0;
   int n_errors = 0;
   int pl_cnt = 0;
   int pr_cnt = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ser_ctl_port dut (
      .clk(clk), .rst_n(rst_n),
      .ser_clk_in(sck), .ser_dat_in(sdat), .ser_lat_in(slat),
      .pin_fmt(pin_fmt), .pin_mute(pin_mute), .pin_intp4(pin_intp4),
      .pin_intp2(pin_intp2), .pin_deemph(pin_deemph),
      .vol_left(vol_left), .vol_right(vol_right),
      .vol_left_new(vol_left_new), .vol_right_new(vol_right_new),
      .deemph_sel(deemph_sel), .fmt_sel(fmt_sel), .mute(mute), .soft_rst(soft_rst),
      .rj_wlen(rj_wlen), .intp4_sel(intp4_sel), .intp2_sel(intp2_sel)
   );

   assign obs_ctl = {intp2_sel, intp4_sel, rj_wlen, soft_rst, mute, fmt_sel, deemph_sel};

   // count pulse cycles: a pulse longer than one cycle counts twice
   always @(posedge clk) begin
      if (vol_left_new)  pl_cnt++;
      if (vol_right_new) pr_cnt++;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic send_bits(input logic [31:0] bits, input int n, input bit do_latch);
      for (int i = n - 1; i >= 0; i--) begin
         sck  = 1'b0;
         sdat = bits[i];
         #(HALF_SCK);
         sck = 1'b1;
         #(HALF_SCK);
      end
      sck = 1'b0;
      #(HALF_SCK);
      if (do_latch) begin
         slat = 1'b1;
         #(2 * HALF_SCK);
         slat = 1'b0;
      end
      #(2 * HALF_SCK);
   endtask

   task automatic latch_only();
      slat = 1'b1;
      #(2 * HALF_SCK);
      slat = 1'b0;
      #(2 * HALF_SCK);
   endtask

   task automatic chk_defaults(input string req);
      chk(req, "vol_left", 32'(vol_left), 32'h3FFF);
      chk(req, "vol_right", 32'(vol_right), 32'h3FFF);
      chk(req, "control outputs", 32'(obs_ctl), 32'h0);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      int pl0, pr0;
      #64;
      // R1: held in reset
      chk_defaults("R1");
      rst_n = 1'b1;
      #64;
      chk_defaults("R1");
      chk("R1", "no pulses", 32'(pl_cnt + pr_cnt), 32'h0);

      for (int v = 0; v < N_VEC; v++) begin
         pl0 = pl_cnt;
         pr0 = pr_cnt;
         send_bits(32'(T_WORD[v]), 16, 1'b1);
         chk($sformatf("R%0d", T_REQ[v]), $sformatf("vec%0d vol_left", v),
             32'(vol_left), 32'(T_VL[v]));
         chk($sformatf("R%0d", T_REQ[v]), $sformatf("vec%0d vol_right", v),
             32'(vol_right), 32'(T_VR[v]));
         chk($sformatf("R%0d", T_REQ[v]), $sformatf("vec%0d control", v),
             32'(obs_ctl), 32'(T_CTL[v]));
         // R10: pulse count per write
         chk("R10", $sformatf("vec%0d left pulses", v), 32'(pl_cnt - pl0), 32'(T_PL[v]));
         chk("R10", $sformatf("vec%0d right pulses", v), 32'(pr_cnt - pr0), 32'(T_PR[v]));
      end

      // R8: control format=01, then pins set every ORed field
      send_bits(32'h0011, 16, 1'b1);
      chk("R8", "fmt from register", 32'(fmt_sel), 32'h1);
      pin_fmt = 2'b10; pin_mute = 1'b1; pin_intp4 = 1'b1; pin_intp2 = 1'b1;
      #64;
      chk("R8", "fmt ORed", 32'(fmt_sel), 32'h3);
      chk("R8", "mute ORed", 32'(mute), 32'h1);
      chk("R8", "intp4 ORed", 32'(intp4_sel), 32'h1);
      chk("R8", "intp2 ORed", 32'(intp2_sel), 32'h1);
      pin_fmt = 2'b00; pin_mute = 1'b0; pin_intp4 = 1'b0; pin_intp2 = 1'b0;

      // R9: de-emphasis pin over field 00 and field 10
      pin_deemph = 1'b1;
      #64;
      chk("R9", "pin over off", 32'(deemph_sel), 32'h1);
      send_bits(32'h0009, 16, 1'b1);
      chk("R9", "pin over 32k", 32'(deemph_sel), 32'h3);
      pin_deemph = 1'b0;
      #64;
      chk("R9", "field alone", 32'(deemph_sel), 32'h2);

      // R6: 20 bits, first four are junk
      pl0 = pl_cnt;
      send_bits({12'h0, 4'b1011, 16'h3C3C}, 20, 1'b1);
      chk("R6", "last 16 bits loaded", 32'(vol_left), 32'h0F0F);
      chk("R10", "long word pulse", 32'(pl_cnt - pl0), 32'h1);

      // R7: clocks without latch, then lone latch
      pl0 = pl_cnt;
      send_bits(32'h0004, 16, 1'b0);
      chk("R7", "no load without latch", 32'(vol_left), 32'h0F0F);
      chk("R7", "no pulse without latch", 32'(pl_cnt - pl0), 32'h0);
      latch_only();
      chk("R7", "lone latch loads", 32'(vol_left), 32'h0001);
      chk("R7", "lone latch pulse", 32'(pl_cnt - pl0), 32'h1);

      // R11: reset after writes
      send_bits(32'h0ADD, 16, 1'b1);
      chk("R11", "control before reset", 32'(obs_ctl), 32'h2B7);
      rst_n = 1'b0;
      #64;
      chk_defaults("R11");
      rst_n = 1'b1;
      #64;
      chk_defaults("R11");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule